// File: doc/BRIEF.md
# Ping-Pong Line-Doubling Deinterlacer

This block turns an interlaced stream of 24-bit RGB pixels into a progressive stream at twice the line rate. The write side runs on an input pixel clock. It stores every incoming line in one of two line memories. The read side runs on a clock at exactly twice that rate and replays the other memory once per output line. Two output lines therefore fit into one input line period, so each captured line appears twice on the output.

The two memories trade roles on every input start-of-line. The memory that has just been filled becomes the one that is read. The one that was being read becomes the next write target. The write-side buffer selection crosses to the read side through a two-flop synchroniser. The read side only acts on it at the start of an output line. Output line starts and active video come from an external timing generator as a horizontal count and an active flag.

The input stream has no back-pressure. Every cycle with `in_valid` high is accepted, and there is no ready signal because a line doubler cannot stall a live video source. The output has no valid or ready either. It produces a pixel, or black, on every read clock, as the timing generator requires.

Top module: `line_doubler`

## Requirements
- R1: After reset, and until the first input line has been completed by a second `in_sol`, `out_pix` is all zeros on every read cycle, active or not.
- R2: An `in_sol` cycle starts a new line at write address 0. If `in_valid` is also high on that cycle, that pixel is stored at address 0. Each later cycle with `in_valid` high stores the pixel at the next address. Cycles with `in_valid` low store nothing and do not advance the address.
- R3: On each `in_sol`, the memory that was just filled becomes the read memory. The change shows on the output from the first output line whose `rd_hcnt == 0` cycle comes at least three read clocks after that `in_sol`.
- R4: Until the next swap, every output line replays the same stored line from address 0, so consecutive output lines carry identical pixels.
- R5: While `rd_active` is low, the pixel out is all zeros and the read address holds. When active video resumes within the line, the next stored pixel follows on without a skip.
- R6: The pixel read for the address presented on a read clock edge appears on `out_pix` right after that edge. This is one read clock of latency from the `rd_hcnt`/`rd_active` inputs.
- R7: The read address returns to 0 on every read cycle where `rd_hcnt == 0`. If `rd_active` is high on that cycle, the next address is 1.
- R8: A swap that arrives in the middle of an output line does not change the memory being read until the next `rd_hcnt == 0` cycle.
- R9: Input pixels beyond the first DEPTH of a line are dropped. The write address never exceeds DEPTH, and stored entries 0 to DEPTH-1 are not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input pixel clock, half the read clock rate, edge-aligned with it |
| wr_rst_n | input | 1 | Active-low reset for the write side |
| in_valid | input | 1 | Input pixel valid strobe |
| in_sol | input | 1 | Input start-of-line marker, one cycle, may coincide with the first pixel |
| in_pix | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| rd_clk | input | 1 | Output pixel clock, twice the write clock rate |
| rd_rst_n | input | 1 | Active-low reset for the read side |
| rd_hcnt | input | HCNT_W | Horizontal count from the timing generator; 0 marks an output line start |
| rd_active | input | 1 | Active-video flag from the timing generator |
| out_pix | output | 24 | Output pixel, black outside active video |

## Verification
The hardest case to reach is an input start-of-line that lands in the middle of an output line. The bench brings it about by forking a read line against a lone start-of-line pulse delayed by a few write clocks. It checks that the rest of the line still comes from the old memory, and that the following line comes from the new one. A second fork starts an input line and an output line on the same edge, so the swap misses that line start. The overflow case writes more pixels than DEPTH and reads back the last stored entry to confirm it was not overwritten.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

  // One stored pixel: 8 bits per colour.
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } ldb_rgb_t;

  localparam ldb_rgb_t LDB_BLACK = '{r: 8'h00, g: 8'h00, b: 8'h00};

endpackage

// File: rtl/ldb_sync2.sv
// Two-flop level synchroniser into the read clock domain.
module ldb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ldb_line_mem.sv
// One line memory: written on the input clock, read synchronously on the output clock.
module ldb_line_mem
  import ldb_pkg::*;
#(
  parameter int DEPTH  = 858,
  parameter int ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  ldb_rgb_t          wdata,
  input  logic              rd_clk,
  input  logic [ADDR_W-1:0] raddr,
  output ldb_rgb_t          rdata
);
  ldb_rgb_t store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/ldb_wr_ctrl.sv
// Write side: start-of-line handling, write addressing, buffer role swap.
module ldb_wr_ctrl #(
  parameter int DEPTH  = 858,
  parameter int ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sol,
  output logic              we,
  output logic              sel_now,   // buffer targeted this cycle
  output logic [ADDR_W-1:0] addr_now,  // address used this cycle
  output logic              sel_q,     // registered write-buffer select
  output logic [ADDR_W-1:0] addr_q,    // registered write address
  output logic              line_ok    // a complete line exists
);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

  logic started;

  always_comb begin
    sel_now  = in_sol ? ~sel_q : sel_q;
    addr_now = in_sol ? '0 : addr_q;
    we       = in_valid && (addr_now < DEPTH_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      addr_q  <= '0;
      started <= 1'b0;
      line_ok <= 1'b0;
    end else begin
      sel_q  <= sel_now;
      addr_q <= we ? addr_now + 1'b1 : addr_now;
      if (in_sol) begin
        started <= 1'b1;
        if (started) line_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldb_rd_ctrl.sv
// Read side: buffer choice latched at output line start, replay addressing, blanking.
module ldb_rd_ctrl #(
  parameter int DEPTH  = 858,
  parameter int ADDR_W = $clog2(DEPTH + 1),
  parameter int HCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic              active,
  input  logic              wsel_s,    // synchronised write-buffer select
  input  logic              ok_s,      // synchronised complete-line flag
  output logic [ADDR_W-1:0] addr_now,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_q,
  output logic              sel_d,     // select aligned with memory output
  output logic              show_d     // drive stored pixel (else black)
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  logic line_start;
  logic sel_now;
  logic ok_q, ok_now;

  always_comb begin
    line_start = (hcnt == '0);
    sel_now    = line_start ? ~wsel_s : sel_q;
    ok_now     = line_start ? ok_s : ok_q;
    addr_now   = line_start ? '0 : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
      ok_q   <= 1'b0;
      sel_d  <= 1'b0;
      show_d <= 1'b0;
    end else begin
      addr_q <= (active && addr_now < LAST_A) ? addr_now + 1'b1 : addr_now;
      sel_q  <= sel_now;
      ok_q   <= ok_now;
      sel_d  <= sel_now;
      show_d <= active && ok_now;
    end
  end
endmodule

// File: rtl/line_doubler.sv
module line_doubler
  import ldb_pkg::*;
#(
  parameter int DEPTH   = 858,
  parameter int H_TOTAL = 858,
  parameter int HCNT_W  = $clog2(H_TOTAL)
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic [23:0]       in_pix,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [HCNT_W-1:0] rd_hcnt,
  input  logic              rd_active,
  output logic [23:0]       out_pix
);
  localparam int ADDR_W = $clog2(DEPTH + 1);
  localparam int NBUF   = 2;

  logic              wr_we, wr_sel_now, wr_sel, wr_line_ok;
  logic [ADDR_W-1:0] wr_addr_now, wr_addr;
  logic              rd_wsel_s, rd_ok_s;
  logic [ADDR_W-1:0] rd_addr_now, rd_addr;
  logic              rd_sel, rd_sel_d, rd_show_d;
  ldb_rgb_t          mem_q [NBUF];

  ldb_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .in_valid (in_valid),
    .in_sol   (in_sol),
    .we       (wr_we),
    .sel_now  (wr_sel_now),
    .addr_now (wr_addr_now),
    .sel_q    (wr_sel),
    .addr_q   (wr_addr),
    .line_ok  (wr_line_ok)
  );

  ldb_sync2 #(.W(2)) u_sync (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     ({wr_sel, wr_line_ok}),
    .q     ({rd_wsel_s, rd_ok_s})
  );

  ldb_rd_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HCNT_W(HCNT_W)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .hcnt     (rd_hcnt),
    .active   (rd_active),
    .wsel_s   (rd_wsel_s),
    .ok_s     (rd_ok_s),
    .addr_now (rd_addr_now),
    .addr_q   (rd_addr),
    .sel_q    (rd_sel),
    .sel_d    (rd_sel_d),
    .show_d   (rd_show_d)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    ldb_line_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .wr_clk (wr_clk),
      .we     (wr_we && (wr_sel_now == 1'(b))),
      .waddr  (wr_addr_now),
      .wdata  (ldb_rgb_t'(in_pix)),
      .rd_clk (rd_clk),
      .raddr  (rd_addr_now),
      .rdata  (mem_q[b])
    );
  end

  always_comb begin
    out_pix = rd_show_d ? 24'(mem_q[rd_sel_d]) : 24'(LDB_BLACK);
  end
endmodule

// File: rtl/line_doubler_chk.sv
module line_doubler_chk #(
  parameter int DEPTH  = 858,
  parameter int ADDR_W = 10,
  parameter int HCNT_W = 10
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              in_valid,
  input logic              in_sol,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic [HCNT_W-1:0] rd_hcnt,
  input logic              rd_active,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_sel,
  input logic [23:0]       out_pix
);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

  // R2
  wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && !in_sol && wr_addr < DEPTH_A) |=> (wr_addr == $past(wr_addr) + 1'b1));

  // R2
  wr_idle_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!in_valid && !in_sol) |=> $stable(wr_addr));

  // R9
  wr_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_addr <= DEPTH_A);

  // R5
  blank_black_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_active |=> (out_pix == 24'h0));

  // R5
  blank_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_active && rd_hcnt != '0) |=> $stable(rd_addr));

  // R7
  line_restart_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_active && rd_hcnt == '0) |=> (rd_addr == ADDR_W'(1)));

  // R8
  sel_midline_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_hcnt != '0) |=> $stable(rd_sel));
endmodule

bind line_doubler line_doubler_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .HCNT_W(HCNT_W)
) u_chk (
  .wr_clk    (wr_clk),
  .wr_rst_n  (wr_rst_n),
  .in_valid  (in_valid),
  .in_sol    (in_sol),
  .wr_addr   (wr_addr),
  .rd_clk    (rd_clk),
  .rd_rst_n  (rd_rst_n),
  .rd_hcnt   (rd_hcnt),
  .rd_active (rd_active),
  .rd_addr   (rd_addr),
  .rd_sel    (rd_sel),
  .out_pix   (out_pix)
);

// File: tb/line_doubler_tb.sv
module line_doubler_tb;
  localparam int RD_PERIOD = 10;
  localparam int DEPTH     = 16;
  localparam int H_TOTAL   = 20;
  localparam int HCNT_W    = $clog2(H_TOTAL);

  logic              wr_clk = 1'b0, rd_clk = 1'b0;
  logic              wr_rst_n, rd_rst_n;
  logic              in_valid, in_sol;
  logic [23:0]       in_pix;
  logic [HCNT_W-1:0] rd_hcnt;
  logic              rd_active;
  logic [23:0]       out_pix;

  int n_checks = 0;
  int n_fail   = 0;

  line_doubler #(.DEPTH(DEPTH), .H_TOTAL(H_TOTAL)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_pix(in_pix), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_hcnt(rd_hcnt),
    .rd_active(rd_active), .out_pix(out_pix)
  );

  always #(RD_PERIOD / 2) rd_clk = ~rd_clk;
  always @(posedge rd_clk) wr_clk <= ~wr_clk;

  function automatic logic [23:0] pix(input logic [7:0] tag, input int i);
    return {tag, 8'(i), 8'(8'hA5 ^ 8'(i))};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_pix=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Write side: in_sol with the first pixel; a blank cycle after every gap_every pixels.
  task automatic write_line(input logic [7:0] tag, input int n, input int gap_every);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      in_sol   = (i == 0);
      in_valid = 1'b1;
      in_pix   = pix(tag, i);
      if (gap_every > 0 && i % gap_every == gap_every - 1) begin
        @(negedge wr_clk);
        in_sol   = 1'b0;
        in_valid = 1'b0;
        in_pix   = 24'hFFFFFF;
      end
    end
    @(negedge wr_clk);
    in_sol   = 1'b0;
    in_valid = 1'b0;
    in_pix   = 24'h0;
  endtask

  task automatic sol_pulse(input logic [7:0] tag);
    @(negedge wr_clk);
    in_sol = 1'b1; in_valid = 1'b1; in_pix = pix(tag, 0);
    @(negedge wr_clk);
    in_sol = 1'b0; in_valid = 1'b0; in_pix = 24'h0;
  endtask

  // Read side: one output line, active for the first DEPTH counts except [glo, ghi).
  task automatic read_line(input logic [7:0] tag, input logic ok, input int glo,
                           input int ghi, input string req);
    int idx = 0;
    logic [23:0] exp_prev = 24'h0;
    for (int h = 0; h < H_TOTAL; h++) begin
      logic act;
      @(negedge rd_clk);
      if (h > 0) check(req, out_pix, exp_prev);
      act       = (h < DEPTH + (ghi - glo)) && !(h >= glo && h < ghi);
      rd_hcnt   = HCNT_W'(h);
      rd_active = act;
      exp_prev  = (act && ok) ? pix(tag, idx) : 24'h0;
      if (act && idx < DEPTH - 1) idx++;
    end
    @(negedge rd_clk);
    check(req, out_pix, exp_prev);
    rd_hcnt   = HCNT_W'(1);
    rd_active = 1'b0;
  endtask

  task automatic idle_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    idle_rd(2);
    check("R1 reset", out_pix, 24'h0);
    write_line(8'h11, DEPTH, 3);         // line A, with gaps (R2), not yet complete
    idle_rd(4);
    read_line(8'h11, 1'b0, 0, 0, "R1 no complete line");
  endtask

  task automatic t_double();
    write_line(8'h22, DEPTH, 0);         // line B; its in_sol completes A
    idle_rd(4);
    read_line(8'h11, 1'b1, 0, 0, "R3/R6 swap to A, R2 gaps");
    read_line(8'h11, 1'b1, 0, 0, "R4 second replay of A");
  endtask

  task automatic t_blank();
    read_line(8'h11, 1'b1, 4, 7, "R5 blank gap holds address");
    read_line(8'h11, 1'b1, 0, 0, "R7 restart at address 0");
  endtask

  task automatic t_overflow();
    fork
      write_line(8'h33, DEPTH + 4, 0);   // line C overflows; in_sol completes B
      read_line(8'h11, 1'b1, 0, 0, "R3 swap too late for this line");
    join
    idle_rd(4);
    read_line(8'h22, 1'b1, 0, 0, "R3 read B");
    write_line(8'h44, DEPTH, 0);         // line D; completes C
    idle_rd(4);
    read_line(8'h33, 1'b1, 0, 0, "R9 overflow dropped");
  endtask

  task automatic t_midline();
    fork
      read_line(8'h33, 1'b1, 0, 0, "R8 mid-line swap ignored");
      begin
        repeat (6) @(negedge wr_clk);
        sol_pulse(8'h55);                // line E starts; D becomes readable
      end
    join
    idle_rd(4);
    read_line(8'h44, 1'b1, 0, 0, "R3/R8 swap at next line start");
  endtask

  initial begin
    #(RD_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    in_valid = 1'b0; in_sol = 1'b0; in_pix = 24'h0;
    rd_hcnt = HCNT_W'(1); rd_active = 1'b0;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    t_reset();
    t_double();
    t_blank();
    t_overflow();
    t_midline();
    finish_run();
  end
endmodule